// File: doc/BRIEF.md
# Auto-Sampling Thermal Shutdown Controller

This block sits between an external temperature-sensor converter and a register bus. Once started by software, it waits out a programmable interval and then converts each enabled sensor source in turn, lowest index first. Each conversion is a one-cycle request carrying the source index, followed by a wait for the converter's data-valid strobe. The code that comes back is stored per source and compared against that source's shutdown threshold. The converter's code falls as temperature rises, so a source is hot when its code is at or below its threshold.

A source that stays hot for a programmable number of consecutive samples trips. A trip drives a shutdown request to the clock/reset unit, and separately to an external pin, each through its own per-source route enable. The pin's active level is programmable and defaults to active low. While any source has a run of hot samples in progress, the controller switches to a separate "hot" sampling interval. A trip is sticky: it holds the shutdown outputs and a status flag until reset, even if sampling is switched off.

Register map (byte offsets, 32-bit words): control at 0x00, routing at 0x08, latest code for source i at 0x20+4i (read-only), threshold for source i at 0x40+4i, debounce count at 0x64, normal interval at 0x68, hot interval at 0x6C.

Top module: `thermguard_top`

## Requirements
- R1: After reset, shut_cru is 0 and shut_pin is 1. The control register reads 0, both interval registers read 10, and the debounce register reads 4.
- R2: While control bit 0 (run) is set, each sampling round converts only the sources whose enable bit is set (control bits 4..7 for sources 0..3), in ascending index order. Each conversion is an adc_req pulse with adc_chan equal to the source index.
- R3: On adc_valid, the code is stored for the source being converted and reads back at 0x20+4i. Bus writes to these registers are ignored.
- R4: A sample is hot when its code is less than or equal to the source's threshold at 0x40+4i. A source trips on the hot sample that makes the run of consecutive hot samples equal to the debounce count. A sample that is not hot clears the run.
- R5: shut_cru is 1 when a tripped source has its routing bit 8+i set. The pin is active when a tripped source has its routing bit 4+i set. The two routes are independent.
- R6: Control bit 8 selects the pin level. When the bit is 1 the pin is active high, and when it is 0 the pin is active low. The bit takes effect immediately, including after a trip.
- R7: Control bit 24 reads 1 once any source has tripped. Neither this flag nor the shutdown outputs clear on bus writes or when run is cleared; only reset clears them.
- R8: With run cleared, no further adc_req is issued.
- R9: After a round ends, the next round's first request follows the data-valid cycle by the interval plus 2 cycles. The interval is the normal one (0x68), or the hot one (0x6C) when any source has a nonzero run of hot samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Access is a write when 1 |
| bus_addr | input | 8 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| adc_req | output | 1 | One-cycle conversion request |
| adc_chan | output | 2 | Source index of the request |
| adc_data | input | 12 | Conversion code from the converter |
| adc_valid | input | 1 | Conversion code is valid this cycle |
| shut_cru | output | 1 | Shutdown request to clock/reset unit |
| shut_pin | output | 1 | Shutdown pin, programmable polarity |

## Verification
The bench builds the block with its default package constants: four sources, 12-bit codes, 16-bit intervals and a 4-bit debounce count. Because the intervals are registers rather than constants, the bench programs a normal interval of 3 and a hot interval of 6. This makes the switch between the two intervals visible as a difference of three cycles in the gap between requests. A debounce count of 1 lets the routing and polarity cases reach a trip in a single sample. The default count of 4 is kept for the debounce case, which covers a run broken by a cool sample and an equal-to-threshold sample.

// File: rtl/thermguard_pkg.sv
package thermguard_pkg;

    localparam int N_SRC  = 4;
    localparam int IDX_W  = $clog2(N_SRC);
    localparam int CODE_W = 12;
    localparam int PER_W  = 16;
    localparam int DB_W   = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // control word field positions
    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_SRC_LSB  = 4;
    localparam int CTL_POL_BIT  = 8;
    localparam int CTL_TRIP_BIT = 24;

    // routing word field positions
    localparam int RTE_PIN_LSB = 4;
    localparam int RTE_CRU_LSB = 8;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ROUTE   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA0   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_THR0    = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_DEB     = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_PER     = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_PER_HOT = 8'h6C;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_REQ,
        SQ_BUSY
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [CODE_W-1:0] code;
    } sample_t;

    typedef logic [N_SRC-1:0][CODE_W-1:0] code_vec_t;

    // Lowest enabled source whose index is at least 'from'; MSB flags a hit.
    function automatic logic [IDX_W:0] pick_src(input logic [N_SRC-1:0] en, input int from);
        logic [IDX_W:0] r;
        r = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (en[i] && (i >= from)) begin
                r = {1'b1, IDX_W'(i)};
            end
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base, input int i);
        return base + ADDR_W'(4 * i);
    endfunction

endpackage

// File: rtl/thermguard_judge.sv
module thermguard_judge
    import thermguard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sample_t          smp,
    input  code_vec_t        thr,
    input  logic [DB_W-1:0]  deb,
    output code_vec_t        data_q,
    output logic [N_SRC-1:0] trip_vec,
    output logic             hot
);

    logic [N_SRC-1:0] run_nz;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [DB_W-1:0]   cnt_q;
        logic [DB_W:0]     cnt_nx;
        logic [CODE_W-1:0] code_q;
        logic              trip_q;
        logic              hit;
        logic              over;

        assign hit    = smp.valid && (smp.idx == IDX_W'(g));
        assign over   = smp.code <= thr[g];
        assign cnt_nx = {1'b0, cnt_q} + 1'b1;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q  <= '0;
                code_q <= '0;
                trip_q <= 1'b0;
            end else if (hit) begin
                code_q <= smp.code;
                if (over) begin
                    if (cnt_q != '1) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (cnt_nx >= {1'b0, deb}) begin
                        trip_q <= 1'b1;
                    end
                end else begin
                    cnt_q <= '0;
                end
            end
        end

        assign data_q[g]   = code_q;
        assign trip_vec[g] = trip_q;
        assign run_nz[g]   = (cnt_q != '0);
    end

    assign hot = |run_nz;

endmodule

// File: rtl/thermguard_seq.sv
module thermguard_seq
    import thermguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [N_SRC-1:0]  src_en,
    input  logic [PER_W-1:0]  per_norm,
    input  logic [PER_W-1:0]  per_hot,
    input  logic              hot,
    input  logic              adc_valid,
    input  logic [CODE_W-1:0] adc_data,
    output logic              adc_req,
    output logic [IDX_W-1:0]  adc_chan,
    output sample_t           smp
);

    seq_state_e       st_q;
    logic [PER_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [PER_W-1:0] per_lim;
    logic [IDX_W:0]   first_hit;
    logic [IDX_W:0]   next_hit;

    assign per_lim   = hot ? per_hot : per_norm;
    assign first_hit = pick_src(src_en, 0);
    assign next_hit  = pick_src(src_en, int'(idx_q) + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (run) begin
                        st_q  <= SQ_WAIT;
                        cnt_q <= '0;
                    end
                end
                SQ_WAIT: begin
                    if (!run) begin
                        st_q <= SQ_IDLE;
                    end else if (cnt_q >= per_lim) begin
                        cnt_q <= '0;
                        if (first_hit[IDX_W]) begin
                            idx_q <= first_hit[IDX_W-1:0];
                            st_q  <= SQ_REQ;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_REQ: begin
                    st_q <= SQ_BUSY;
                end
                SQ_BUSY: begin
                    if (adc_valid) begin
                        if (run && next_hit[IDX_W]) begin
                            idx_q <= next_hit[IDX_W-1:0];
                            st_q  <= SQ_REQ;
                        end else begin
                            st_q  <= run ? SQ_WAIT : SQ_IDLE;
                            cnt_q <= '0;
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign adc_req   = (st_q == SQ_REQ);
    assign adc_chan  = idx_q;
    assign smp.valid = (st_q == SQ_BUSY) && adc_valid;
    assign smp.idx   = idx_q;
    assign smp.code  = adc_data;

endmodule

// File: rtl/thermguard_regs.sv
module thermguard_regs
    import thermguard_pkg::*;
#(
    parameter logic [PER_W-1:0] PER_RST = 16'd10,
    parameter logic [DB_W-1:0]  DEB_RST = 4'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  code_vec_t         data_q,
    input  logic              trip_any,
    output logic              run,
    output logic [N_SRC-1:0]  src_en,
    output logic              pin_hi,
    output logic [N_SRC-1:0]  pin_route,
    output logic [N_SRC-1:0]  cru_route,
    output code_vec_t         thr,
    output logic [PER_W-1:0]  per_norm,
    output logic [PER_W-1:0]  per_hot,
    output logic [DB_W-1:0]   deb
);

    logic wr;
    logic unused_wdata;

    assign wr           = bus_sel && bus_wr;
    assign unused_wdata = ^bus_wdata[DATA_W-1:PER_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            src_en    <= '0;
            pin_hi    <= 1'b0;
            pin_route <= '0;
            cru_route <= '0;
            per_norm  <= PER_RST;
            per_hot   <= PER_RST;
            deb       <= DEB_RST;
        end else if (wr) begin
            case (bus_addr)
                OFS_CTRL: begin
                    run    <= bus_wdata[CTL_RUN_BIT];
                    src_en <= bus_wdata[CTL_SRC_LSB +: N_SRC];
                    pin_hi <= bus_wdata[CTL_POL_BIT];
                end
                OFS_ROUTE: begin
                    pin_route <= bus_wdata[RTE_PIN_LSB +: N_SRC];
                    cru_route <= bus_wdata[RTE_CRU_LSB +: N_SRC];
                end
                OFS_PER:     per_norm <= bus_wdata[PER_W-1:0];
                OFS_PER_HOT: per_hot  <= bus_wdata[PER_W-1:0];
                OFS_DEB:     deb      <= bus_wdata[DB_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_thr
        logic [CODE_W-1:0] thr_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                thr_q <= '0;
            end else if (wr && (bus_addr == slot_addr(OFS_THR0, g))) begin
                thr_q <= bus_wdata[CODE_W-1:0];
            end
        end
        assign thr[g] = thr_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_CTRL: begin
                    bus_rdata[CTL_RUN_BIT]           = run;
                    bus_rdata[CTL_SRC_LSB +: N_SRC]  = src_en;
                    bus_rdata[CTL_POL_BIT]           = pin_hi;
                    bus_rdata[CTL_TRIP_BIT]          = trip_any;
                end
                OFS_ROUTE: begin
                    bus_rdata[RTE_PIN_LSB +: N_SRC] = pin_route;
                    bus_rdata[RTE_CRU_LSB +: N_SRC] = cru_route;
                end
                OFS_PER:     bus_rdata[PER_W-1:0] = per_norm;
                OFS_PER_HOT: bus_rdata[PER_W-1:0] = per_hot;
                OFS_DEB:     bus_rdata[DB_W-1:0]  = deb;
                default: ;
            endcase
            for (int i = 0; i < N_SRC; i++) begin
                if (bus_addr == slot_addr(OFS_DATA0, i)) begin
                    bus_rdata[CODE_W-1:0] = data_q[i];
                end
                if (bus_addr == slot_addr(OFS_THR0, i)) begin
                    bus_rdata[CODE_W-1:0] = thr[i];
                end
            end
        end
    end

endmodule

// File: rtl/thermguard_top.sv
module thermguard_top
    import thermguard_pkg::*;
#(
    parameter logic [PER_W-1:0] PER_RST = 16'd10,
    parameter logic [DB_W-1:0]  DEB_RST = 4'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              adc_req,
    output logic [IDX_W-1:0]  adc_chan,
    input  logic [CODE_W-1:0] adc_data,
    input  logic              adc_valid,
    output logic              shut_cru,
    output logic              shut_pin
);

    logic             run_en;
    logic [N_SRC-1:0] src_en;
    logic             pin_hi;
    logic [N_SRC-1:0] pin_route;
    logic [N_SRC-1:0] cru_route;
    code_vec_t        thr;
    code_vec_t        data_q;
    logic [PER_W-1:0] per_norm;
    logic [PER_W-1:0] per_hot;
    logic [DB_W-1:0]  deb;
    logic [N_SRC-1:0] trip_vec;
    logic             hot;
    logic             pin_active;
    sample_t          smp;

    thermguard_regs #(
        .PER_RST (PER_RST),
        .DEB_RST (DEB_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .trip_any  (|trip_vec),
        .run       (run_en),
        .src_en    (src_en),
        .pin_hi    (pin_hi),
        .pin_route (pin_route),
        .cru_route (cru_route),
        .thr       (thr),
        .per_norm  (per_norm),
        .per_hot   (per_hot),
        .deb       (deb)
    );

    thermguard_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (run_en),
        .src_en    (src_en),
        .per_norm  (per_norm),
        .per_hot   (per_hot),
        .hot       (hot),
        .adc_valid (adc_valid),
        .adc_data  (adc_data),
        .adc_req   (adc_req),
        .adc_chan  (adc_chan),
        .smp       (smp)
    );

    thermguard_judge u_judge (
        .clk      (clk),
        .rst      (rst),
        .smp      (smp),
        .thr      (thr),
        .deb      (deb),
        .data_q   (data_q),
        .trip_vec (trip_vec),
        .hot      (hot)
    );

    assign shut_cru   = |(trip_vec & cru_route);
    assign pin_active = |(trip_vec & pin_route);
    assign shut_pin   = pin_hi ? pin_active : ~pin_active;

endmodule

// File: rtl/thermguard_chk.sv
module thermguard_chk
    import thermguard_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             adc_req,
    input logic             adc_valid,
    input logic             run_en,
    input logic [N_SRC-1:0] trip_vec,
    input code_vec_t        data_q
);

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        adc_req |=> !adc_req); // R2

    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        adc_req |-> $past(run_en)); // R8

    AST_DATA_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        !$past(adc_valid) |-> $stable(data_q)); // R3

    AST_TRIP_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (trip_vec != $past(trip_vec)) |-> $past(adc_valid)); // R4

    AST_TRIP_HELD: assert property (@(posedge clk) disable iff (rst)
        (($past(trip_vec) & ~trip_vec) == '0)); // R7

endmodule

bind thermguard_top thermguard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .adc_req   (adc_req),
    .adc_valid (adc_valid),
    .run_en    (run_en),
    .trip_vec  (trip_vec),
    .data_q    (data_q)
);

// File: tb/tb_thermguard_top.sv
module tb_thermguard_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        adc_req;
    logic [1:0]  adc_chan;
    logic [11:0] adc_data;
    logic        adc_valid;
    logic        shut_cru;
    logic        shut_pin;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    thermguard_top dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .adc_req   (adc_req),
        .adc_chan  (adc_chan),
        .adc_data  (adc_data),
        .adc_valid (adc_valid),
        .shut_cru  (shut_cru),
        .shut_pin  (shut_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        adc_valid = 1'b0; adc_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Converter model: answer the next request two cycles later.
    task automatic serve(input int exp_chan, input logic [11:0] code);
        int k = 0;
        while (!adc_req && k < 300) begin
            @(negedge clk);
            k++;
        end
        chk("R2 request seen", int'(adc_req), 1);
        chk("R2 channel", int'(adc_chan), exp_chan);
        @(negedge clk);
        @(negedge clk);
        adc_valid = 1'b1; adc_data = code;
        @(negedge clk);
        adc_valid = 1'b0;
    endtask

    task automatic gap_check(input int exp_gap);
        int n = 1;
        while (!adc_req && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R9 interval", n, exp_gap);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 shut_cru", int'(shut_cru), 0);
        chk("R1 shut_pin", int'(shut_pin), 1);
        bus_read(8'h00, d); chk("R1 control", int'(d), 0);
        bus_read(8'h68, d); chk("R1 interval", int'(d), 10);
        bus_read(8'h6C, d); chk("R1 hot interval", int'(d), 10);
        bus_read(8'h64, d); chk("R1 debounce", int'(d), 4);
    endtask

    task automatic t_order();
        logic [31:0] d;
        do_reset();
        bus_write(8'h68, 32'd3);
        bus_write(8'h00, 32'h61);
        serve(1, 12'h111);
        serve(2, 12'h222);
        serve(1, 12'h333);
        serve(2, 12'h444);
        bus_write(8'h24, 32'h5);
        bus_read(8'h24, d); chk("R3 data src1", int'(d), 'h333);
        bus_read(8'h28, d); chk("R3 data src2", int'(d), 'h444);
        bus_read(8'h20, d); chk("R3 data src0 untouched", int'(d), 0);
    endtask

    task automatic t_debounce();
        do_reset();
        bus_write(8'h40, 32'd3437);
        bus_write(8'h08, 32'h100);
        bus_write(8'h68, 32'd3);
        bus_write(8'h00, 32'h11);
        serve(0, 12'd3000); serve(0, 12'd3000); serve(0, 12'd3000);
        chk("R4 three hot samples", int'(shut_cru), 0);
        serve(0, 12'd4000);
        chk("R4 cool sample", int'(shut_cru), 0);
        serve(0, 12'd3437); serve(0, 12'd3000); serve(0, 12'd3000);
        chk("R4 run restarted", int'(shut_cru), 0);
        serve(0, 12'd3000);
        chk("R4 trip on fourth", int'(shut_cru), 1);
        chk("R5 pin not routed", int'(shut_pin), 1);
    endtask

    task automatic t_route();
        do_reset();
        bus_write(8'h64, 32'd1);
        bus_write(8'h44, 32'd4095);
        bus_write(8'h08, 32'h120);
        bus_write(8'h68, 32'd3);
        bus_write(8'h00, 32'h131);
        chk("R6 high polarity idle", int'(shut_pin), 0);
        serve(0, 12'd100);
        serve(1, 12'd100);
        chk("R5 pin route src1", int'(shut_pin), 1);
        chk("R5 cru route src0 only", int'(shut_cru), 0);
        bus_write(8'h00, 32'h31);
        chk("R6 low polarity active", int'(shut_pin), 0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        int seen = 0;
        do_reset();
        bus_write(8'h64, 32'd1);
        bus_write(8'h40, 32'd4095);
        bus_write(8'h08, 32'h110);
        bus_write(8'h68, 32'd3);
        bus_write(8'h00, 32'h11);
        serve(0, 12'd5);
        chk("R5 cru after trip", int'(shut_cru), 1);
        chk("R6 pin active low", int'(shut_pin), 0);
        bus_read(8'h00, d); chk("R7 flag set", int'(d[24]), 1);
        bus_write(8'h00, 32'h0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (adc_req) seen++;
        end
        chk("R8 no request when stopped", seen, 0);
        bus_read(8'h00, d); chk("R7 flag held", int'(d[24]), 1);
        chk("R7 cru held", int'(shut_cru), 1);
    endtask

    task automatic t_period();
        do_reset();
        bus_write(8'h40, 32'd2000);
        bus_write(8'h64, 32'd8);
        bus_write(8'h68, 32'd3);
        bus_write(8'h6C, 32'd6);
        bus_write(8'h00, 32'h11);
        serve(0, 12'd3000);
        gap_check(5);
        serve(0, 12'd1000);
        gap_check(8);
        serve(0, 12'd3000);
        gap_check(5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        t_reset();
        t_order();
        t_debounce();
        t_route();
        t_sticky();
        t_period();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule